// File: doc/BRIEF.md
# Status FIS Response Builder

This block forms the two status frames a storage host port deposits in its received-frame area: the 32-byte device-to-host register frame, which reports the ATA status after a command, and the 8-byte set-device-bits frame, which reports completion of queued commands. It sends each frame as a stream of single-byte writes, one byte per cycle, with an area-relative offset. On the last byte of each frame it pulses the matching port interrupt-status set lines.

A register-frame request captures the ATA status and error bytes, the host interrupt-pending flag and bytes 4 to 13 of the command frame that caused it. Instead of the command bytes, the request can select the power-on image, which differs for packet devices. A queued-completion request names one tag and says whether that tag failed. It updates the per-tag active and error vectors and the accumulated finished-tag bitmap, and then queues a set-device-bits frame. Both frame kinds are gated by the receive-enable and area-valid inputs. Each kind has a one-deep pending slot. A single emitter sends the pending frames one at a time.

The emitter is a three-state machine. In `ST_IDLE` it takes `IDLE->D2H` when a register frame is pending, or `IDLE->SDB` when only a bits frame is pending. In `ST_D2H` it emits 32 bytes and then takes `D2H->IDLE`. In `ST_SDB` it emits 8 bytes and then takes `SDB->IDLE`. A return to idle always lasts at least one cycle.

Top module: `fis_resp_builder`

## Requirements
- R1: A register-frame or completion request sampled while `rx_en` or `area_valid` is low queues no frame, causes no write and no interrupt pulse, and leaves `fin_map` unchanged. The per-tag updates of R9 still take place.
- R2: Register-frame bytes 0 to 3 are 0x34, then `{1'b0, host_irq_pend, 6'b0}`, then status, then error, with all values taken at the request.
- R3: A register frame is written at offsets `D2H_BASE` to `D2H_BASE+31` in ascending order, one byte per cycle with no gaps. Bytes 4 to 13 equal `cmd_bytes`, with byte 4 in bits [7:0] and byte n in bits [8(n-4)+7 : 8(n-4)]. Bytes 14 to 31 are zero.
- R4: `irq_d2h` pulses during the cycle of register-frame byte 31. `irq_tfe` pulses in the same cycle only when bit 0 (ERR) of the frame's status byte is set.
- R5: With `d2h_init` high, the command bytes are replaced by an image that is zero except for byte 4 = 1 and byte 12 = 1. When `dev_packet` is also high, byte 5 = 0x14 and byte 6 = 0xEB.
- R6: A bits frame is written at offsets `SDB_BASE` to `SDB_BASE+7`, one byte per cycle. Byte 0 is the error byte, byte 2 is the status AND 0x77, and bytes 1 and 3 are zero.
- R7: Bits-frame bytes 4 to 7 hold the finished-tag bitmap in little-endian order (tag t is bit t). Each accepted completion ORs its tag into `fin_map`. `sact_read` clears `fin_map`, but a tag accepted in the same cycle survives the clear.
- R8: `irq_sdb` pulses during the cycle of bits-frame byte 7.
- R9: `sact_set` ORs bits into `sact`. A completion clears its tag's `sact` bit, and this clear wins over a set in the same cycle. If `cmp_err` is high, the completion also sets the tag's `serr` bit and reports status 0x41 and error 0x04; otherwise it reports `ata_status` and `ata_error`.
- R10: After a request is sampled on edge t, the first byte of its frame appears in the cycle after edge t+1 if the emitter is idle. When both kinds are pending, the register frame goes first. A request arriving while the slot for its kind is full replaces that slot's contents.
- R11: While `rst_n` is low, `wr_valid` and all interrupt pulses are low, and `sact`, `serr` and `fin_map` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Frame reception enabled |
| area_valid | input | 1 | Receive area configured |
| host_irq_pend | input | 1 | Host-level interrupt status nonzero |
| ata_status | input | 8 | Current ATA status byte |
| ata_error | input | 8 | Current ATA error byte |
| d2h_req | input | 1 | Request a register frame |
| d2h_init | input | 1 | Use the power-on image instead of `cmd_bytes` |
| dev_packet | input | 1 | Attached device is a packet device |
| cmd_bytes | input | 80 | Command-frame bytes 4..13 |
| cmp_req | input | 1 | Queued-command completion |
| cmp_tag | input | $clog2(TAGS) | Completed tag |
| cmp_err | input | 1 | Completion failed |
| sact_set | input | TAGS | Bits to set in the active vector |
| sact_read | input | 1 | Active vector read, clears the finished bitmap |
| wr_valid | output | 1 | Byte write strobe |
| wr_off | output | OFF_W | Offset of the byte in the receive area |
| wr_data | output | 8 | Byte value |
| irq_d2h | output | 1 | Set the register-frame interrupt bit |
| irq_tfe | output | 1 | Set the task-file-error interrupt bit |
| irq_sdb | output | 1 | Set the bits-frame interrupt bit |
| sact | output | TAGS | Active-tag vector |
| serr | output | TAGS | Per-tag error vector |
| fin_map | output | TAGS | Accumulated finished-tag bitmap |

## Verification
The hardest case to reach is a pair of pending slots that fill while the emitter is busy. For example, a register request and a completion can land in the same cycle, or a second register request can overwrite a slot before that slot has been drained. The stimulus reaches these cases by issuing requests in consecutive cycles and in the same cycle as a running frame. The reference model then has to predict which snapshot wins and in what order the frames come out. A second hard case is a completion that coincides with `sact_read`; the stimulus drives both in one cycle so that the surviving bitmap can be seen in the frame that follows.

// File: rtl/fis_resp_pkg.sv
package fis_resp_pkg;

    localparam int D2H_LEN = 32;
    localparam int SDB_LEN = 8;
    localparam int CNT_W   = $clog2(D2H_LEN);
    localparam int MAP_W   = 32;
    localparam int CMD_W   = 80;

    localparam logic [7:0] D2H_TYPE_CODE   = 8'h34;
    localparam logic [7:0] SDB_STATUS_MASK = 8'h77;
    localparam logic [7:0] CPL_ERR_STATUS  = 8'h41;
    localparam logic [7:0] CPL_ERR_CODE    = 8'h04;
    localparam int         ATA_ERR_BIT     = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_D2H  = 2'd1,
        ST_SDB  = 2'd2
    } emit_state_e;

    typedef struct packed {
        logic             ibit;
        logic [7:0]       status;
        logic [7:0]       error;
        logic [CMD_W-1:0] cmd;
    } d2h_snap_t;

    typedef struct packed {
        logic [7:0]       status;
        logic [7:0]       error;
        logic [MAP_W-1:0] map;
    } sdb_snap_t;

    // Command image for the power-on register frame.
    function automatic logic [CMD_W-1:0] power_on_image(input logic packet);
        logic [CMD_W-1:0] img;
        img          = '0;
        img[7:0]     = 8'h01;   // byte 4
        img[71:64]   = 8'h01;   // byte 12
        if (packet) begin
            img[15:8]  = 8'h14; // byte 5
            img[23:16] = 8'hEB; // byte 6
        end
        return img;
    endfunction

endpackage

// File: rtl/fis_tag_tracker.sv
module fis_tag_tracker
    import fis_resp_pkg::*;
#(
    parameter int TAGS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_req,
    input  logic [$clog2(TAGS)-1:0] cmp_tag,
    input  logic                    cmp_err,
    input  logic                    gate,
    input  logic [TAGS-1:0]         sact_set,
    input  logic                    sact_read,
    output logic [TAGS-1:0]         sact_q,
    output logic [TAGS-1:0]         serr_q,
    output logic [TAGS-1:0]         fin_q,
    output logic [TAGS-1:0]         fin_next
);
    localparam int TAG_W = $clog2(TAGS);

    for (genvar t = 0; t < TAGS; t++) begin : g_tag
        logic hit;
        assign hit         = cmp_req && (cmp_tag == TAG_W'(t));
        // A tag accepted in the same cycle survives a clearing read.
        assign fin_next[t] = (fin_q[t] & ~sact_read) | (hit & gate);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sact_q[t] <= 1'b0;
                serr_q[t] <= 1'b0;
                fin_q[t]  <= 1'b0;
            end else begin
                sact_q[t] <= (sact_q[t] | sact_set[t]) & ~hit;
                serr_q[t] <= serr_q[t] | (hit & cmp_err);
                fin_q[t]  <= fin_next[t];
            end
        end
    end

endmodule

// File: rtl/fis_req_slots.sv
module fis_req_slots
    import fis_resp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      d2h_acc,
    input  d2h_snap_t d2h_new,
    input  logic      start_d2h,
    input  logic      sdb_acc,
    input  sdb_snap_t sdb_new,
    input  logic      start_sdb,
    output logic      d2h_pend,
    output d2h_snap_t d2h_slot,
    output logic      sdb_pend,
    output sdb_snap_t sdb_slot
);
    // A newly accepted request wins over the start that drains the slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d2h_pend <= 1'b0;
            sdb_pend <= 1'b0;
            d2h_slot <= '0;
            sdb_slot <= '0;
        end else begin
            if (d2h_acc) begin
                d2h_pend <= 1'b1;
                d2h_slot <= d2h_new;
            end else if (start_d2h) begin
                d2h_pend <= 1'b0;
            end
            if (sdb_acc) begin
                sdb_pend <= 1'b1;
                sdb_slot <= sdb_new;
            end else if (start_sdb) begin
                sdb_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fis_byte_gen.sv
module fis_byte_gen
    import fis_resp_pkg::*;
(
    input  logic             is_sdb,
    input  logic [CNT_W-1:0] idx,
    input  d2h_snap_t        d2h,
    input  sdb_snap_t        sdb,
    output logic [7:0]       byte_o
);
    logic [3:0] rel;

    always_comb begin
        rel    = 4'(idx - CNT_W'(4));
        byte_o = 8'h00;
        if (!is_sdb) begin
            if (idx == CNT_W'(0))                          byte_o = D2H_TYPE_CODE;
            else if (idx == CNT_W'(1))                     byte_o = {1'b0, d2h.ibit, 6'b0};
            else if (idx == CNT_W'(2))                     byte_o = d2h.status;
            else if (idx == CNT_W'(3))                     byte_o = d2h.error;
            else if (idx >= CNT_W'(4) && idx <= CNT_W'(13)) byte_o = d2h.cmd[int'(rel)*8 +: 8];
            else                                           byte_o = 8'h00;
        end else begin
            if (idx == CNT_W'(0))                          byte_o = sdb.error;
            else if (idx == CNT_W'(2))                     byte_o = sdb.status & SDB_STATUS_MASK;
            else if (idx >= CNT_W'(4) && idx <= CNT_W'(7))  byte_o = sdb.map[int'(rel[1:0])*8 +: 8];
            else                                           byte_o = 8'h00;
        end
    end

endmodule

// File: rtl/fis_resp_builder.sv
module fis_resp_builder
    import fis_resp_pkg::*;
#(
    parameter int TAGS     = 32,
    parameter int OFF_W    = 8,
    parameter int D2H_BASE = 'h40,
    parameter int SDB_BASE = 'h60
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    area_valid,
    input  logic                    host_irq_pend,
    input  logic [7:0]              ata_status,
    input  logic [7:0]              ata_error,
    input  logic                    d2h_req,
    input  logic                    d2h_init,
    input  logic                    dev_packet,
    input  logic [79:0]             cmd_bytes,
    input  logic                    cmp_req,
    input  logic [$clog2(TAGS)-1:0] cmp_tag,
    input  logic                    cmp_err,
    input  logic [TAGS-1:0]         sact_set,
    input  logic                    sact_read,
    output logic                    wr_valid,
    output logic [OFF_W-1:0]        wr_off,
    output logic [7:0]              wr_data,
    output logic                    irq_d2h,
    output logic                    irq_tfe,
    output logic                    irq_sdb,
    output logic [TAGS-1:0]         sact,
    output logic [TAGS-1:0]         serr,
    output logic [TAGS-1:0]         fin_map
);
    localparam logic [CNT_W-1:0] D2H_LAST = CNT_W'(D2H_LEN - 1);
    localparam logic [CNT_W-1:0] SDB_LAST = CNT_W'(SDB_LEN - 1);

    logic        gate, d2h_acc, sdb_acc;
    logic        d2h_pend, sdb_pend, start_d2h, start_sdb;
    d2h_snap_t   d2h_new, d2h_slot, d2h_work;
    sdb_snap_t   sdb_new, sdb_slot, sdb_work;
    logic [TAGS-1:0] fin_next;
    emit_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [7:0]  byte_val;

    assign gate    = rx_en & area_valid;
    assign d2h_acc = d2h_req & gate;
    assign sdb_acc = cmp_req & gate;

    assign d2h_new.ibit   = host_irq_pend;
    assign d2h_new.status = ata_status;
    assign d2h_new.error  = ata_error;
    assign d2h_new.cmd    = d2h_init ? power_on_image(dev_packet) : cmd_bytes;

    assign sdb_new.status = cmp_err ? CPL_ERR_STATUS : ata_status;
    assign sdb_new.error  = cmp_err ? CPL_ERR_CODE   : ata_error;
    assign sdb_new.map    = MAP_W'(fin_next);

    fis_tag_tracker #(.TAGS(TAGS)) tracker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_req  (cmp_req),
        .cmp_tag  (cmp_tag),
        .cmp_err  (cmp_err),
        .gate     (gate),
        .sact_set (sact_set),
        .sact_read(sact_read),
        .sact_q   (sact),
        .serr_q   (serr),
        .fin_q    (fin_map),
        .fin_next (fin_next)
    );

    fis_req_slots slots_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .d2h_acc  (d2h_acc),
        .d2h_new  (d2h_new),
        .start_d2h(start_d2h),
        .sdb_acc  (sdb_acc),
        .sdb_new  (sdb_new),
        .start_sdb(start_sdb),
        .d2h_pend (d2h_pend),
        .d2h_slot (d2h_slot),
        .sdb_pend (sdb_pend),
        .sdb_slot (sdb_slot)
    );

    fis_byte_gen bytes_i (
        .is_sdb(state_q == ST_SDB),
        .idx   (cnt_q),
        .d2h   (d2h_work),
        .sdb   (sdb_work),
        .byte_o(byte_val)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        start_d2h = 1'b0;
        start_sdb = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (d2h_pend) begin
                    state_d   = ST_D2H;
                    cnt_d     = '0;
                    start_d2h = 1'b1;
                end else if (sdb_pend) begin
                    state_d   = ST_SDB;
                    cnt_d     = '0;
                    start_sdb = 1'b1;
                end
            end
            ST_D2H: begin
                if (cnt_q == D2H_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_SDB: begin
                if (cnt_q == SDB_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register and working snapshots
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            d2h_work <= '0;
            sdb_work <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start_d2h) d2h_work <= d2h_slot;
            if (start_sdb) sdb_work <= sdb_slot;
        end
    end

    // Outputs
    always_comb begin
        wr_valid = 1'b0;
        wr_off   = '0;
        wr_data  = 8'h00;
        irq_d2h  = 1'b0;
        irq_tfe  = 1'b0;
        irq_sdb  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_D2H: begin
                wr_valid = 1'b1;
                wr_off   = OFF_W'(D2H_BASE) + OFF_W'(cnt_q);
                wr_data  = byte_val;
                if (cnt_q == D2H_LAST) begin
                    irq_d2h = 1'b1;
                    irq_tfe = d2h_work.status[ATA_ERR_BIT];
                end
            end
            ST_SDB: begin
                wr_valid = 1'b1;
                wr_off   = OFF_W'(SDB_BASE) + OFF_W'(cnt_q);
                wr_data  = byte_val;
                irq_sdb  = (cnt_q == SDB_LAST);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fis_resp_builder_chk.sv
module fis_resp_builder_chk #(
    parameter int TAGS     = 32,
    parameter int OFF_W    = 8,
    parameter int D2H_BASE = 'h40,
    parameter int SDB_BASE = 'h60
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rx_en,
    input logic                    area_valid,
    input logic                    d2h_req,
    input logic                    cmp_req,
    input logic [$clog2(TAGS)-1:0] cmp_tag,
    input logic                    cmp_err,
    input logic                    wr_valid,
    input logic [OFF_W-1:0]        wr_off,
    input logic [7:0]              wr_data,
    input logic                    irq_d2h,
    input logic                    irq_tfe,
    input logic                    irq_sdb,
    input logic [TAGS-1:0]         sact,
    input logic [TAGS-1:0]         serr,
    input logic                    d2h_pend,
    input logic                    sdb_pend
);
    localparam logic [OFF_W-1:0] D2H_0    = OFF_W'(D2H_BASE);
    localparam logic [OFF_W-1:0] D2H_14   = OFF_W'(D2H_BASE + 14);
    localparam logic [OFF_W-1:0] D2H_END  = OFF_W'(D2H_BASE + 31);
    localparam logic [OFF_W-1:0] SDB_1    = OFF_W'(SDB_BASE + 1);
    localparam logic [OFF_W-1:0] SDB_2    = OFF_W'(SDB_BASE + 2);
    localparam logic [OFF_W-1:0] SDB_END  = OFF_W'(SDB_BASE + 7);

    // R1: with nothing queued or running and no accepted request, no write follows
    p_gate_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !d2h_pend && !sdb_pend &&
         !(rx_en && area_valid && (d2h_req || cmp_req))) |=> !wr_valid);

    // R2: frame type byte
    p_d2h_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_off == D2H_0) |-> wr_data == 8'h34);

    // R3: zero tail of the register frame
    p_d2h_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_off >= D2H_14 && wr_off <= D2H_END) |-> wr_data == 8'h00);

    // R3: bytes of a frame come on consecutive offsets in consecutive cycles
    p_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_off != D2H_END && wr_off != SDB_END) |=>
        (wr_valid && wr_off == $past(wr_off) + OFF_W'(1)));

    // R4: interrupt pulses tied to the last register byte
    p_d2h_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_d2h |-> (wr_valid && wr_off == D2H_END));
    p_tfe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tfe |-> irq_d2h);

    // R6: reserved and masked bits-frame bytes
    p_sdb_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_off == SDB_1) |-> wr_data == 8'h00);
    p_sdb_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_off == SDB_2) |-> (wr_data & 8'h88) == 8'h00);

    // R8: bits-frame interrupt only on its last byte, never with the register one
    p_sdb_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sdb |-> (wr_valid && wr_off == SDB_END));
    p_irq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_d2h, irq_sdb}));

    // R9: completion clears active bit and records failure
    p_sact_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req |=> !sact[$past(cmp_tag)]);
    p_serr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_err) |=> serr[$past(cmp_tag)]);

endmodule

bind fis_resp_builder fis_resp_builder_chk #(
    .TAGS    (TAGS),
    .OFF_W   (OFF_W),
    .D2H_BASE(D2H_BASE),
    .SDB_BASE(SDB_BASE)
) chk_i (.*);

// File: tb/fis_resp_builder_tb_top.sv
`timescale 1ns/1ps
module fis_resp_builder_tb_top;

    localparam int D2H_B = 'h40;
    localparam int SDB_B = 'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, area_valid = 1'b0, host_irq_pend = 1'b0;
    logic [7:0]  ata_status = '0, ata_error = '0;
    logic        d2h_req = 1'b0, d2h_init = 1'b0, dev_packet = 1'b0;
    logic [79:0] cmd_bytes = '0;
    logic        cmp_req = 1'b0, cmp_err = 1'b0, sact_read = 1'b0;
    logic [4:0]  cmp_tag = '0;
    logic [31:0] sact_set = '0;
    logic        wr_valid, irq_d2h, irq_tfe, irq_sdb;
    logic [7:0]  wr_off, wr_data;
    logic [31:0] sact, serr, fin_map;

    always #2 clk = ~clk;

    fis_resp_builder dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .area_valid(area_valid),
        .host_irq_pend(host_irq_pend), .ata_status(ata_status), .ata_error(ata_error),
        .d2h_req(d2h_req), .d2h_init(d2h_init), .dev_packet(dev_packet),
        .cmd_bytes(cmd_bytes), .cmp_req(cmp_req), .cmp_tag(cmp_tag), .cmp_err(cmp_err),
        .sact_set(sact_set), .sact_read(sact_read), .wr_valid(wr_valid),
        .wr_off(wr_off), .wr_data(wr_data), .irq_d2h(irq_d2h), .irq_tfe(irq_tfe),
        .irq_sdb(irq_sdb), .sact(sact), .serr(serr), .fin_map(fin_map)
    );

    typedef struct {
        int off;
        int data;
        bit d2h;
        bit tfe;
        bit sdb;
        int rq;
    } exp_t;

    exp_t        act[$];
    int          vectors = 0;
    int          fails   = 0;
    int          focus   = 11;
    bit          done    = 1'b0;

    // Reference model state
    bit          d2h_p = 0, sdb_p = 0;
    logic [7:0]  s_st, s_er, q_st, q_er;
    bit          s_ib, s_init;
    logic [79:0] s_cmd;
    logic [31:0] q_map;
    logic [31:0] m_sact = '0, m_serr = '0, m_fin = '0;

    function automatic logic [79:0] init_img(input bit pkt);
        logic [79:0] v;
        v = '0;
        v[7:0]   = 8'd1;
        v[71:64] = 8'd1;
        if (pkt) begin
            v[15:8]  = 8'h14;
            v[23:16] = 8'hEB;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input int rq, input string what,
                       input longint a, input longint e);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h at %0t", rq, what, a, e, $time);
        end
    endtask

    // Model update at each rising edge, from inputs only
    always @(posedge clk) begin
        logic [31:0] oh, nf;
        bit g;
        exp_t r;
        if (!rst_n) begin
            act.delete();
            d2h_p = 0; sdb_p = 0;
            m_sact = '0; m_serr = '0; m_fin = '0;
        end else begin
            if (act.size() > 0) begin
                act.delete(0);
            end else if (d2h_p) begin
                for (int i = 0; i < 32; i++) begin
                    r.off = D2H_B + i;
                    if (i == 0)      r.data = 'h34;
                    else if (i == 1) r.data = s_ib ? 'h40 : 'h00;
                    else if (i == 2) r.data = s_st;
                    else if (i == 3) r.data = s_er;
                    else if (i <= 13) r.data = s_cmd[(i-4)*8 +: 8];
                    else             r.data = 0;
                    r.d2h = (i == 31);
                    r.tfe = (i == 31) && s_st[0];
                    r.sdb = 0;
                    r.rq  = (i < 4) ? 2 : ((i <= 13 && s_init) ? 5 : 3);
                    act.push_back(r);
                end
                d2h_p = 0;
            end else if (sdb_p) begin
                for (int i = 0; i < 8; i++) begin
                    r.off = SDB_B + i;
                    if (i == 0)      r.data = q_er;
                    else if (i == 2) r.data = q_st & 8'h77;
                    else if (i >= 4) r.data = q_map[(i-4)*8 +: 8];
                    else             r.data = 0;
                    r.d2h = 0; r.tfe = 0;
                    r.sdb = (i == 7);
                    r.rq  = (i < 4) ? 6 : 7;
                    act.push_back(r);
                end
                sdb_p = 0;
            end
            g  = rx_en && area_valid;
            oh = 32'd1 << cmp_tag;
            if (d2h_req && g) begin
                d2h_p = 1;
                s_st = ata_status; s_er = ata_error; s_ib = host_irq_pend;
                s_init = d2h_init;
                s_cmd = d2h_init ? init_img(dev_packet) : cmd_bytes;
            end
            nf = sact_read ? 32'd0 : m_fin;
            if (cmp_req && g) begin
                nf = nf | oh;
                sdb_p = 1;
                q_st = cmp_err ? 8'h41 : ata_status;
                q_er = cmp_err ? 8'h04 : ata_error;
                q_map = nf;
            end
            m_fin  = nf;
            m_sact = (m_sact | sact_set) & ~(cmp_req ? oh : 32'd0);
            m_serr = m_serr | ((cmp_req && cmp_err) ? oh : 32'd0);
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        exp_t e;
        bit ev;
        int lv;
        ev = act.size() > 0;
        lv = !rst_n ? 11 : focus;
        if (ev) e = act[0];
        chk(wr_valid == ev, ev ? e.rq : lv, "wr_valid", wr_valid, ev);
        if (ev && wr_valid) begin
            chk(wr_off == 8'(e.off), e.rq, "wr_off", wr_off, e.off);
            chk(wr_data == 8'(e.data), e.rq, "wr_data", wr_data, e.data);
            chk(irq_d2h == e.d2h && irq_tfe == e.tfe, 4, "irq_d2h/tfe",
                {irq_d2h, irq_tfe}, {e.d2h, e.tfe});
            chk(irq_sdb == e.sdb, 8, "irq_sdb", irq_sdb, e.sdb);
        end else begin
            chk({irq_d2h, irq_tfe, irq_sdb} == 3'b000, lv, "irq idle",
                {irq_d2h, irq_tfe, irq_sdb}, 0);
        end
        chk(sact == m_sact, rst_n ? 9 : 11, "sact", sact, m_sact);
        chk(serr == m_serr, rst_n ? 9 : 11, "serr", serr, m_serr);
        chk(fin_map == m_fin, rst_n ? 7 : 11, "fin_map", fin_map, m_fin);
    end

    task automatic step();
        @(negedge clk);
        d2h_req = 0; cmp_req = 0; sact_read = 0; sact_set = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R11: reset state
        focus = 11;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9: fill the active vector
        focus = 9;
        sact_set = 32'hFFFF_FFFF;
        step();
        rx_en = 1; area_valid = 1;

        // R2 R3 R4 R10: plain register frame, no error, host idle
        focus = 10;
        ata_status = 8'h50; ata_error = 8'h00;
        cmd_bytes = 80'h0D0C_0B0A_0908_0706_0504;
        d2h_req = 1; step(); idle(40);

        // R4: ERR set, host interrupt pending
        host_irq_pend = 1; ata_status = 8'h51; ata_error = 8'h04;
        cmd_bytes = 80'hFFEE_DDCC_BBAA_9988_7766;
        d2h_req = 1; step(); idle(40);

        // R5: power-on images, disk and packet
        host_irq_pend = 0; ata_status = 8'h50; ata_error = 8'h01;
        d2h_init = 1; dev_packet = 0; d2h_req = 1; step(); idle(40);
        dev_packet = 1; d2h_req = 1; step(); idle(40);
        d2h_init = 0; dev_packet = 0;

        // R6 R7 R8: successful completions with mask, accumulating bitmap
        focus = 7;
        ata_status = 8'hFF; ata_error = 8'h00;
        cmp_tag = 5'd3; cmp_req = 1; step(); idle(15);
        cmp_tag = 5'd31; cmp_req = 1; step(); idle(15);
        // R9: failed completion
        cmp_tag = 5'd0; cmp_err = 1; cmp_req = 1; step(); idle(15);
        cmp_err = 0;

        // R7: read clears bitmap; a tag in the same cycle survives
        sact_read = 1; step(); idle(2);
        cmp_tag = 5'd9; cmp_req = 1; sact_read = 1; step(); idle(15);

        // R10: both kinds in one cycle, register frame first
        focus = 10;
        ata_status = 8'h50; cmd_bytes = 80'h1234_5678_9ABC_DEF0_1357;
        cmp_tag = 5'd12; d2h_req = 1; cmp_req = 1; step(); idle(50);

        // R10: back-to-back requests replace the pending snapshot
        ata_status = 8'h40; d2h_req = 1; step();
        ata_status = 8'h41; d2h_req = 1; step();
        ata_status = 8'h50; d2h_req = 1; step();
        cmp_tag = 5'd20; cmp_req = 1; step();
        cmp_tag = 5'd21; cmp_req = 1; step();
        idle(120);

        // R1: gated off requests
        focus = 1;
        rx_en = 0;
        d2h_req = 1; step();
        cmp_tag = 5'd7; cmp_req = 1; step(); idle(10);
        rx_en = 1; area_valid = 0;
        d2h_req = 1; step();
        cmp_tag = 5'd8; cmp_err = 1; cmp_req = 1; step(); idle(10);
        cmp_err = 0; area_valid = 1;

        // R11: reset during a frame
        focus = 10;
        d2h_req = 1; step(); idle(8);
        focus = 11;
        rst_n = 0; idle(3);
        rst_n = 1; idle(5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule